// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a port of general-purpose input pins and raises one shared interrupt when any pin meets the condition chosen for it. Each pin has its own control word on a simple register bus. A four-bit mode code in that word selects the detection rule: off, active-low level, active-high level, rising edge, falling edge, or any edge. The pins are first passed through a synchronizer. Edges are then found by comparing each synchronized value with its value one clock earlier.

A detected event sets that pin's bit in a shared flag word. Bits stay set until software writes a one to them; writing a zero leaves a bit alone. The interrupt output is high whenever any flag is set. A typical interrupt handler reads the flag word, services the pins it finds, and writes the same value back to clear them. Reads are combinational from the current register state.

Top module: `gpio_irq_detect`

## Requirements
- R1: Pin n's control word is at byte offset 4*n (n = 0..31). A write stores only bits 19:16 as the mode code. A read returns the code in bits 19:16 and zero in every other bit.
- R2: Code 0x0, and every code other than 0x8, 0x9, 0xA, 0xB and 0xC, never sets the pin's flag.
- R3: Code 0x8 sets the flag on every cycle in which the synchronized pin is 0.
- R4: Code 0xC sets the flag on every cycle in which the synchronized pin is 1.
- R5: Code 0x9 sets the flag when the synchronized pin goes from 0 to 1.
- R6: Code 0xA sets the flag when the synchronized pin goes from 1 to 0.
- R7: Code 0xB sets the flag on any change of the synchronized pin.
- R8: The flag word is read and written at byte offset 0xA0, with bit n for pin n. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R9: Writing 0xFFFFFFFF to offset 0xA0 clears every flag in the same cycle.
- R10: If an event and a clearing write hit the same flag in the same cycle, the flag stays set. A level-mode flag whose condition still holds is set again right after it is cleared.
- R11: `irq_out` is high exactly when at least one flag is set.
- R12: Reset clears every control word and every flag.
- R13: A pin change applied between clock edges is reflected in the flags after the third following rising edge (two synchronizer stages plus the flag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 32 | Raw pin levels |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_out | output | 1 | Shared interrupt request |

## Verification
On every cycle, the assertions check four things. A disabled or undefined code never produces an event. A rising-edge event only occurs on a real 0-to-1 change. A set flag survives unless a clearing write targets it. A flag can only appear from an event, and a level-high condition re-sets its flag on the next cycle. Only the bench scenarios can show the rest: the per-mode flag patterns under chosen pin sequences, the exact three-edge latency, the outcome when a clear lands in the same cycle as an edge event, and the readback format of the control words.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int CFG_W   = 4;
    localparam int CFG_LSB = 16;
    localparam int STAT_OFS = 'hA0;

    localparam logic [CFG_W-1:0] MODE_OFF  = 4'h0;
    localparam logic [CFG_W-1:0] MODE_LOW  = 4'h8;
    localparam logic [CFG_W-1:0] MODE_RISE = 4'h9;
    localparam logic [CFG_W-1:0] MODE_FALL = 4'hA;
    localparam logic [CFG_W-1:0] MODE_ANY  = 4'hB;
    localparam logic [CFG_W-1:0] MODE_HIGH = 4'hC;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = raw;
        for (int k = 1; k < STAGES; k++) begin
            s_d.chain[k] = s_q.chain[k-1];
        end
        s_d.last = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur  = s_q.chain[STAGES-1];
    assign prev = s_q.last;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic [CFG_W-1:0] mode,
    input  logic             cur,
    input  logic             prev,
    output logic             evt
);
    always_comb begin
        case (mode)
            MODE_LOW:  evt = !cur;
            MODE_HIGH: evt = cur;
            MODE_RISE: evt = cur && !prev;
            MODE_FALL: evt = !cur && prev;
            MODE_ANY:  evt = cur ^ prev;
            default:   evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                irq_out
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_OFS);

    typedef struct packed {
        logic [NUM_PINS-1:0][CFG_W-1:0] cfg;
        logic [NUM_PINS-1:0]            flags;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_PINS-1:0] pin_cur, pin_prev, evt, clr_mask;
    logic [IDX_W-1:0]    word_idx;
    logic                cfg_hit, stat_hit;

    gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_pin_detect u_det (
            .mode(r_q.cfg[i]),
            .cur (pin_cur[i]),
            .prev(pin_prev[i]),
            .evt (evt[i])
        );
    end

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (int'(word_idx) < NUM_PINS);
    assign stat_hit = (bus_addr == STAT_ADDR);
    assign clr_mask = (bus_en && bus_we && stat_hit) ? bus_wdata[NUM_PINS-1:0] : '0;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_en && bus_we && cfg_hit && word_idx == IDX_W'(i)) begin
                r_d.cfg[i] = bus_wdata[CFG_LSB +: CFG_W];
            end
        end
        // an event in the same cycle as a clear keeps the flag
        r_d.flags = (r_q.flags & ~clr_mask) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (stat_hit) begin
            bus_rdata[NUM_PINS-1:0] = r_q.flags;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (cfg_hit && word_idx == IDX_W'(i)) begin
                    bus_rdata[CFG_LSB +: CFG_W] = r_q.cfg[i];
                end
            end
        end
    end

    assign irq_out = |r_q.flags;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        assert_undef_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.cfg[i] != MODE_LOW && r_q.cfg[i] != MODE_HIGH && r_q.cfg[i] != MODE_RISE &&
             r_q.cfg[i] != MODE_FALL && r_q.cfg[i] != MODE_ANY) |-> !evt[i]);
        assert_rise_real_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.cfg[i] == MODE_RISE && evt[i]) |-> (pin_cur[i] && !pin_prev[i]));
        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.flags[i] && !clr_mask[i]) |=> r_q.flags[i]);
        assert_level_reassert_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.cfg[i] == MODE_HIGH && pin_cur[i]) |=> r_q.flags[i]);
        assert_flag_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!r_q.flags[i] && !evt[i]) |=> !r_q.flags[i]);
    end
endmodule

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int total = 0;
    int bad = 0;

    gpio_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    initial begin
        #(2000000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] model_evt(input logic [3:0] c, input logic [31:0] p,
                                              input logic [31:0] q);
        case (c)
            4'h8: return ~q;
            4'hC: return q;
            4'h9: return q & ~p;
            4'hA: return p & ~q;
            4'hB: return p ^ q;
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h8: return "R3";
            4'hC: return "R4";
            4'h9: return "R5";
            4'hA: return "R6";
            4'hB: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic set_all_cfg(input logic [3:0] c);
        for (int n = 0; n < 32; n++) wr(8'(4 * n), 32'hFFF0_FFFF | (32'(c) << 16));
    endtask

    initial begin
        logic [31:0] d, lv_a, lv_b, ev, expv;
        logic [31:0] pat_a [4];
        logic [31:0] pat_b [4];
        pat_a[0] = 32'hA5F0_0F5A; pat_b[0] = 32'h3C3C_FF00;
        pat_a[1] = 32'h3C3C_FF00; pat_b[1] = 32'hA5F0_0F5A;
        pat_a[2] = 32'h0000_0000; pat_b[2] = 32'hFFFF_FFFF;
        pat_a[3] = 32'hFFFF_FFFF; pat_b[3] = 32'h1248_8421;

        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R12: reset state
        for (int n = 0; n < 32; n++) begin
            rd(8'(4 * n), d);
            chk("R12 cfg after reset", d, 32'h0);
        end
        rd(8'hA0, d);
        chk("R12 flags after reset", d, 32'h0);
        chk("R12 irq after reset", {31'b0, irq_out}, 32'h0);

        // R1: every control word, every code, extra bits dropped
        for (int n = 0; n < 32; n++) wr(8'(4 * n), 32'hFFF0_FFFF | (32'(n % 16) << 16));
        for (int n = 0; n < 32; n++) begin
            rd(8'(4 * n), d);
            chk("R1 cfg readback", d, 32'(n % 16) << 16);
        end
        set_all_cfg(4'h0);

        // R2..R7, R9, R10, R11, R13: all codes over several pin patterns
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                set_all_cfg(4'h0);
                pin_in = pat_a[p];
                wait_n(5);
                wr(8'hA0, 32'hFFFF_FFFF);
                set_all_cfg(4'(c));
                wr(8'hA0, 32'hFFFF_FFFF);
                lv_a = model_evt(4'(c), pat_a[p], pat_a[p]);
                rd(8'hA0, d);
                chk({req_of(4'(c)), " R9 after full clear"}, d, lv_a);
                chk("R11 irq steady", {31'b0, irq_out}, {31'b0, |lv_a});

                pin_in = pat_b[p];
                wait_n(5);
                lv_b = model_evt(4'(c), pat_b[p], pat_b[p]);
                ev   = model_evt(4'(c), pat_a[p], pat_b[p]);
                expv = lv_a | ev | lv_b;
                rd(8'hA0, d);
                chk({req_of(4'(c)), " flags after pattern change"}, d, expv);
                chk("R11 irq after change", {31'b0, irq_out}, {31'b0, |expv});

                wr(8'hA0, 32'hFFFF_FFFF);
                rd(8'hA0, d);
                chk("R10 level re-set after clear", d, lv_b);
            end
        end

        // R8: partial clear and zero write
        set_all_cfg(4'h0);
        pin_in = '0;
        wait_n(5);
        set_all_cfg(4'h9);
        wr(8'hA0, 32'hFFFF_FFFF);
        pin_in = 32'hFFFF_FFFF;
        wait_n(5);
        rd(8'hA0, d);
        chk("R8 all rising flags", d, 32'hFFFF_FFFF);
        wr(8'hA0, 32'h0000_FFFF);
        rd(8'hA0, d);
        chk("R8 partial clear", d, 32'hFFFF_0000);
        wr(8'hA0, 32'h0000_0000);
        rd(8'hA0, d);
        chk("R8 zero write no effect", d, 32'hFFFF_0000);
        chk("R11 irq with half flags", {31'b0, irq_out}, 32'h1);
        wr(8'hA0, 32'hFFFF_0000);
        rd(8'hA0, d);
        chk("R8 remaining cleared", d, 32'h0);
        chk("R11 irq low when empty", {31'b0, irq_out}, 32'h0);

        // R13: exact latency, rising on pin 3
        pin_in = '0;
        wait_n(5);
        wr(8'hA0, 32'hFFFF_FFFF);
        @(negedge clk);
        pin_in[3] = 1'b1;
        @(negedge clk); #1;
        chk("R13 not after edge 1", {31'b0, irq_out}, 32'h0);
        @(negedge clk); #1;
        chk("R13 not after edge 2", {31'b0, irq_out}, 32'h0);
        @(negedge clk); #1;
        chk("R13 set after edge 3", {31'b0, irq_out}, 32'h1);

        // R10: edge event and clear in the same cycle
        set_all_cfg(4'h0);
        wr(8'h00, 32'h000B_0000);
        pin_in = '0;
        wait_n(5);
        wr(8'hA0, 32'hFFFF_FFFF);
        pin_in[0] = 1'b1;
        wait_n(5);
        rd(8'hA0, d);
        chk("R7 any-edge rise on pin 0", d, 32'h1);
        @(negedge clk);
        pin_in[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        rd(8'hA0, d);
        chk("R10 event beats clear", d, 32'h1);
        wr(8'hA0, 32'h1);
        rd(8'hA0, d);
        chk("R10 clear without event", d, 32'h0);

        // R12: reset in the middle of operation
        wr(8'h00, 32'h0008_0000);
        wait_n(4);
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        rd(8'h00, d);
        chk("R12 cfg cleared by reset", d, 32'h0);
        rd(8'hA0, d);
        chk("R12 flags cleared by reset", d, 32'h0);
        chk("R12 irq cleared by reset", {31'b0, irq_out}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule